// File: doc/BRIEF.md
# Prescaled One-Shot / Periodic Timer

This block is one timer channel. It counts down or up, runs once or repeats, and signals two events: a timeout when the count reaches its limit and a match when the count equals a programmed compare value. An 8-bit prescale value sets how the channel counts. When it counts down, the prescale value acts as a true clock divider and the 16-bit counter steps only after the prescaler has run down to zero. When it counts up, the prescale value becomes the upper eight bits of a 24-bit count that sits above the 16-bit counter.

Software programs the channel through a small write port. There is one address for each of the interval load value, the compare value, the prescale value, the prescale compare bits and a mode word. New load and compare values are first staged. They are then applied either on the following clock or at the next timeout, and a separate mode bit chooses this for each group. While the channel is stopped, a staged value is applied at once, so it is in force when the channel starts. A stall input freezes the channel in place.

The outputs are the current counter value, the live prescaler value, a running flag, and one-cycle timeout and match pulses. A host timer unit uses the block by writing the load and prescale values, then writing the mode word with the enable bit set, and then watching the pulses.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `count` is 0xFFFF, `prescaleSnap` is 0, `running` is 0 and neither pulse is high. The staged and active load values reset to 0xFFFF, the compare value to 0xFFFF, and the prescale and prescale compare values to 0.
- R2: Counting down with prescale value P, the prescaler steps from P to 0, one step per active clock. Only when the prescaler is at 0 does the counter decrement, and on that step the prescaler returns to P. The divide ratio is therefore P+1.
- R3: Counting up, the 24-bit value {prescaleSnap, count} starts at 0 and rises by one on every active clock, with a carry from the counter into the prescaler bits.
- R4: Counting down, a timeout occurs on the step taken from count 0 with prescaler 0, which gives a period of (L+1)*(P+1) clocks. Counting up, it occurs on the step taken from {P, L}, which gives a period of P*65536+L+1 clocks. In the cycle where `timeoutPulse` is high, the outputs already show the restart value: (L, P) when counting down and 0 when counting up.
- R5: With mode bit 1 at 0 (one-shot), the timeout clears `running` and the count then stays at its restart value. With bit 1 at 1 (periodic), the channel keeps running with the same period.
- R6: With mode bit 2 at 0, a load or prescale write made while the channel runs is applied on the clock after the write, and the count restarts from the new start value on that clock.
- R7: With mode bit 2 at 1, a load or prescale write does not disturb the current period. The new value is first used at the next timeout restart and sets the period after it.
- R8: With mode bit 3 at 0, a new compare value is in force from the clock after the write. With bit 3 at 1, the old compare value stays in force until the next timeout.
- R9: When mode bit 4 is 1, `matchPulse` goes high for one cycle in the cycle where {prescaleSnap, count} first equals {prescale compare, compare}. When bit 4 is 0, it never goes high.
- R10: While `stall` is high, `count` and `prescaleSnap` hold their values and neither pulse fires. When `stall` is released, counting resumes where it stopped.
- R11: The write addresses are 0 for load, 1 for compare, 2 for prescale, 3 for prescale compare and 4 for the mode word. Writing the mode word with bit 0 set while the channel is stopped starts it. On that same clock the count goes to (L, P) when counting down or to 0 when counting up, including any value staged while the channel was stopped. Writing bit 0 as 0 stops the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 3 | Write address (0 load, 1 compare, 2 prescale, 3 prescale compare, 4 mode) |
| wrData | input | 16 | Write data |
| stall | input | 1 | Freeze counting and events |
| countUp | input | 1 | 1 counts up, 0 counts down; change only while stopped |
| count | output | 16 | Current counter value |
| prescaleSnap | output | 8 | Current prescaler value |
| running | output | 1 | Channel enabled |
| timeoutPulse | output | 1 | One-cycle timeout event |
| matchPulse | output | 1 | One-cycle compare event |

## Verification
The assertions check, on every cycle, the local stepping rules. These are that the prescaler falls by one while the counter holds when counting down, and that the 24-bit value rises by one when counting up. They also check that a down-count timeout follows only from the zero state, that stall freezes the state and silences both pulses, that pulses come only from active steps, and that the channel starts only through a mode write. The full periods, the one-shot stop, and the timing of staged load and compare updates in both modes span many cycles. Only the bench scenarios show these, by measuring pulse spacing against (L+1)*(P+1) and L+1 over a sweep of small load and prescale values, plus one run through the 16-bit carry.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LOAD    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MATCH   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PSCALE  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PSMATCH = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd4;

  // mode word bit positions
  localparam int CTRL_W         = 5;
  localparam int BIT_EN         = 0;
  localparam int BIT_PERIODIC   = 1;
  localparam int BIT_LOAD_LATE  = 2;
  localparam int BIT_MATCH_LATE = 3;
  localparam int BIT_MATCH_EN   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic wrLoad;
    logic wrPscale;
    logic wrMatch;
    logic wrPsMatch;
    logic applyLoad;
    logic applyMatch;
    logic restart;
    logic tick;
  } ptmr_strobe_t;

endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CTRL_W-1:0]   ctrlBits,
  input  logic                stall,
  input  logic                terminal,
  output ptmr_strobe_t        strobe,
  output logic                matchEn,
  output logic                running
);

  logic modePeriodic, modeLoadLate, modeMatchLate, modeMatchEn;
  logic loadPend, matchPend;

  logic wrCtrl, startReq, restartNow, tickNow, wrapNow;
  logic applyLoadNow, applyMatchNow;
  logic wrLoadNow, wrPscaleNow, wrMatchNow, wrPsMatchNow;

  always_comb begin
    wrLoadNow    = wrEn && (wrAddr == ADDR_LOAD);
    wrPscaleNow  = wrEn && (wrAddr == ADDR_PSCALE);
    wrMatchNow   = wrEn && (wrAddr == ADDR_MATCH);
    wrPsMatchNow = wrEn && (wrAddr == ADDR_PSMATCH);
    wrCtrl       = wrEn && (wrAddr == ADDR_CTRL);

    startReq   = wrCtrl && ctrlBits[BIT_EN] && !running;
    restartNow = startReq || (running && loadPend && !modeLoadLate);
    tickNow    = running && !stall && !restartNow;
    wrapNow    = tickNow && terminal;

    applyLoadNow  = loadPend  && (!running || !modeLoadLate  || wrapNow);
    applyMatchNow = matchPend && (!running || !modeMatchLate || wrapNow);
  end

  always_comb begin
    strobe.wrLoad     = wrLoadNow;
    strobe.wrPscale   = wrPscaleNow;
    strobe.wrMatch    = wrMatchNow;
    strobe.wrPsMatch  = wrPsMatchNow;
    strobe.applyLoad  = applyLoadNow;
    strobe.applyMatch = applyMatchNow;
    strobe.restart    = restartNow;
    strobe.tick       = tickNow;
  end

  assign matchEn = modeMatchEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running       <= 1'b0;
      modePeriodic  <= 1'b0;
      modeLoadLate  <= 1'b0;
      modeMatchLate <= 1'b0;
      modeMatchEn   <= 1'b0;
      loadPend      <= 1'b0;
      matchPend     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        running       <= ctrlBits[BIT_EN];
        modePeriodic  <= ctrlBits[BIT_PERIODIC];
        modeLoadLate  <= ctrlBits[BIT_LOAD_LATE];
        modeMatchLate <= ctrlBits[BIT_MATCH_LATE];
        modeMatchEn   <= ctrlBits[BIT_MATCH_EN];
      end else if (wrapNow && !modePeriodic) begin
        running <= 1'b0;
      end
      loadPend  <= (loadPend  && !applyLoadNow)  || wrLoadNow  || wrPscaleNow;
      matchPend <= (matchPend && !applyMatchNow) || wrMatchNow || wrPsMatchNow;
    end
  end

endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptmr_strobe_t       strobe,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               countUp,
  input  logic               matchEn,
  output logic [CNT_W-1:0]   count,
  output logic [PS_W-1:0]    prescaleSnap,
  output logic               terminal,
  output logic               timeoutPulse,
  output logic               matchPulse
);

  localparam int VAL_W = CNT_W + PS_W;

  logic [CNT_W-1:0] stLoad, actLoad, stMatch, actMatch;
  logic [PS_W-1:0]  stPs, actPs, stMps, actMps;
  logic [CNT_W-1:0] effLoad, effMatch, nextCnt;
  logic [PS_W-1:0]  effPs, effMps, nextPs;
  logic [VAL_W-1:0] curVal, limitUp, stepUp;
  logic             matchHit;

  always_comb begin
    effLoad  = strobe.applyLoad  ? stLoad  : actLoad;
    effPs    = strobe.applyLoad  ? stPs    : actPs;
    effMatch = strobe.applyMatch ? stMatch : actMatch;
    effMps   = strobe.applyMatch ? stMps   : actMps;

    curVal   = {prescaleSnap, count};
    limitUp  = {actPs, actLoad};
    stepUp   = curVal + VAL_W'(1);
    terminal = countUp ? (curVal == limitUp) : (curVal == '0);

    nextCnt = count;
    nextPs  = prescaleSnap;
    if (strobe.restart) begin
      if (countUp) begin
        nextCnt = '0;
        nextPs  = '0;
      end else begin
        nextCnt = effLoad;
        nextPs  = effPs;
      end
    end else if (strobe.tick) begin
      if (countUp) begin
        if (terminal) begin
          nextCnt = '0;
          nextPs  = '0;
        end else begin
          {nextPs, nextCnt} = stepUp;
        end
      end else if (terminal) begin
        nextCnt = effLoad;
        nextPs  = effPs;
      end else if (prescaleSnap != '0) begin
        nextPs = prescaleSnap - PS_W'(1);
      end else begin
        nextCnt = count - CNT_W'(1);
        nextPs  = effPs;
      end
    end

    matchHit = ({nextPs, nextCnt} == {effMps, effMatch});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stLoad       <= '1;
      actLoad      <= '1;
      stPs         <= '0;
      actPs        <= '0;
      stMatch      <= '1;
      actMatch     <= '1;
      stMps        <= '0;
      actMps       <= '0;
      count        <= '1;
      prescaleSnap <= '0;
      timeoutPulse <= 1'b0;
      matchPulse   <= 1'b0;
    end else begin
      if (strobe.wrLoad)    stLoad  <= wrData;
      if (strobe.wrPscale)  stPs    <= wrData[PS_W-1:0];
      if (strobe.wrMatch)   stMatch <= wrData;
      if (strobe.wrPsMatch) stMps   <= wrData[PS_W-1:0];
      if (strobe.applyLoad) begin
        actLoad <= stLoad;
        actPs   <= stPs;
      end
      if (strobe.applyMatch) begin
        actMatch <= stMatch;
        actMps   <= stMps;
      end
      count        <= nextCnt;
      prescaleSnap <= nextPs;
      timeoutPulse <= strobe.tick && terminal;
      matchPulse   <= strobe.tick && matchEn && matchHit;
    end
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              stall,
  input  logic              countUp,
  output logic [CNT_W-1:0]  count,
  output logic [PS_W-1:0]   prescaleSnap,
  output logic              running,
  output logic              timeoutPulse,
  output logic              matchPulse
);

  ptmr_strobe_t strobe;
  logic         terminal;
  logic         matchEn;

  ptmr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlBits (wrData[CTRL_W-1:0]),
    .stall    (stall),
    .terminal (terminal),
    .strobe   (strobe),
    .matchEn  (matchEn),
    .running  (running)
  );

  ptmr_datapath #(.CNT_W(CNT_W), .PS_W(PS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .countUp      (countUp),
    .matchEn      (matchEn),
    .count        (count),
    .prescaleSnap (prescaleSnap),
    .terminal     (terminal),
    .timeoutPulse (timeoutPulse),
    .matchPulse   (matchPulse)
  );

endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              enBit,
  input logic              stall,
  input logic              countUp,
  input logic [CNT_W-1:0]  count,
  input logic [PS_W-1:0]   prescaleSnap,
  input logic              running,
  input logic              timeoutPulse,
  input logic              matchPulse,
  input logic              tick,
  input logic              restart
);

  localparam int VAL_W = CNT_W + PS_W;

  assert_down_prescale_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick && !countUp && (prescaleSnap != '0) |=>
      (prescaleSnap == PS_W'($past(prescaleSnap) - PS_W'(1))) && $stable(count));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    tick && countUp |=>
      timeoutPulse || ({prescaleSnap, count} == VAL_W'($past({prescaleSnap, count}) + VAL_W'(1))));

  assert_down_timeout_R4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse && !$past(countUp) |->
      ($past(count) == '0) && ($past(prescaleSnap) == '0));

  assert_match_from_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(tick));

  assert_timeout_from_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(tick) && $past(running));

  assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    stall && !restart |=>
      $stable(count) && $stable(prescaleSnap) && !timeoutPulse && !matchPulse);

  assert_start_by_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(wrEn && (wrAddr == ADDR_CTRL) && enBit));

endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .enBit        (wrData[0]),
  .stall        (stall),
  .countUp      (countUp),
  .count        (count),
  .prescaleSnap (prescaleSnap),
  .running      (running),
  .timeoutPulse (timeoutPulse),
  .matchPulse   (matchPulse),
  .tick         (strobe.tick),
  .restart      (strobe.restart)
);

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;

  localparam logic [2:0] A_LOAD = 3'd0, A_MATCH = 3'd1, A_PSC = 3'd2, A_PSM = 3'd3, A_CTRL = 3'd4;
  localparam logic [15:0] EN = 16'h1, PER = 16'h2, LLATE = 16'h4, MLATE = 16'h8, MEN = 16'h10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, wrEn, stall, countUp;
  logic [2:0]  wrAddr;
  logic [15:0] wrData;
  logic [15:0] count;
  logic [7:0]  prescaleSnap;
  logic        running, timeoutPulse, matchPulse;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  prescaled_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stall(stall), .countUp(countUp), .count(count), .prescaleSnap(prescaleSnap),
    .running(running), .timeoutPulse(timeoutPulse), .matchPulse(matchPulse)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTimeout(input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!timeoutPulse && k < limit);
  endtask

  task automatic waitMatch(input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!matchPulse && k < limit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k, lv, seen;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; stall = 1'b0; countUp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "count", count, 16'hFFFF);
    check("R1", "prescale", prescaleSnap, 0);
    check("R1", "running", running, 0);
    check("R1", "timeout", timeoutPulse, 0);
    check("R1", "match", matchPulse, 0);
    writeReg(A_CTRL, EN | PER);
    check("R1", "reset load at start", count, 16'hFFFF);
    check("R1", "reset prescale at start", prescaleSnap, 0);
    check("R11", "running after start", running, 1);
    writeReg(A_CTRL, 16'h0);
    check("R11", "running after stop", running, 0);

    // R2/R4 down-count sweep
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 3; li++) begin
        int off;
        lv = (li == 2) ? 4 : li;
        writeReg(A_LOAD, 16'(lv));
        writeReg(A_PSC, 16'(p));
        writeReg(A_CTRL, EN | PER);
        check("R11", "down start count", count, lv);
        check("R11", "down start prescale", prescaleSnap, p);
        off = 0;
        if (p > 0) begin
          @(negedge clk);
          off = 1;
          check("R2", "prescale step", prescaleSnap, p - 1);
          check("R2", "count held", count, lv);
        end
        waitTimeout(2000, k);
        check("R4", "down first period", k + off, (lv + 1) * (p + 1));
        check("R4", "reload count", count, lv);
        check("R4", "reload prescale", prescaleSnap, p);
        waitTimeout(2000, k);
        check("R5", "periodic second period", k, (lv + 1) * (p + 1));
        writeReg(A_CTRL, 16'h0);
      end
    end
    writeReg(A_PSC, 16'h0);

    // R3/R4 up-count sweep
    countUp = 1'b1;
    for (int i = 0; i < 4; i++) begin
      int off;
      lv = (i == 3) ? 7 : i;
      writeReg(A_LOAD, 16'(lv));
      writeReg(A_CTRL, EN | PER);
      check("R3", "up start count", count, 0);
      off = 0;
      if (lv >= 2) begin
        @(negedge clk);
        off = 1;
        check("R3", "up step", count, 1);
      end
      waitTimeout(2000, k);
      check("R4", "up period", k + off, lv + 1);
      check("R4", "up wrap count", count, 0);
      writeReg(A_CTRL, 16'h0);
    end
    countUp = 1'b0;

    // R5 one-shot
    writeReg(A_LOAD, 16'd2);
    writeReg(A_CTRL, EN);
    waitTimeout(100, k);
    check("R5", "one-shot period", k, 3);
    check("R5", "one-shot running cleared", running, 0);
    check("R5", "one-shot restart value", count, 2);
    seen = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (timeoutPulse) seen++;
    end
    check("R5", "one-shot no further timeout", seen, 0);
    check("R5", "one-shot count held", count, 2);

    // R10 stall
    writeReg(A_LOAD, 16'd5);
    writeReg(A_PSC, 16'd1);
    writeReg(A_CTRL, EN | PER);
    repeat (3) @(negedge clk);
    stall = 1'b1;
    seen = 0;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (timeoutPulse || matchPulse || count != 16'd4 || prescaleSnap != 8'd0) seen++;
    end
    check("R10", "frozen cycles disturbed", seen, 0);
    stall = 1'b0;
    waitTimeout(200, k);
    check("R10", "resume remaining period", k, 9);
    writeReg(A_CTRL, 16'h0);
    writeReg(A_PSC, 16'h0);

    // R6 immediate load
    writeReg(A_LOAD, 16'd9);
    writeReg(A_CTRL, EN | PER);
    repeat (2) @(negedge clk);
    writeReg(A_LOAD, 16'd4);
    @(negedge clk);
    check("R6", "restart at new load", count, 4);
    waitTimeout(100, k);
    check("R6", "new period", k, 5);
    writeReg(A_CTRL, 16'h0);

    // R7 deferred load
    writeReg(A_LOAD, 16'd3);
    writeReg(A_CTRL, EN | PER | LLATE);
    writeReg(A_LOAD, 16'd6);
    check("R7", "no restart on write", count, 1);
    waitTimeout(100, k);
    check("R7", "old period completes", k, 2);
    check("R7", "reload uses new value", count, 6);
    waitTimeout(100, k);
    check("R7", "new period", k, 7);
    writeReg(A_CTRL, 16'h0);

    // R9/R8 match
    countUp = 1'b1;
    writeReg(A_LOAD, 16'd9);
    writeReg(A_MATCH, 16'd4);
    writeReg(A_CTRL, EN | PER | MEN);
    waitMatch(100, k);
    check("R9", "match delay", k, 4);
    check("R9", "count at match", count, 4);
    writeReg(A_CTRL, 16'h0);
    writeReg(A_CTRL, EN | PER | MEN | MLATE);
    writeReg(A_MATCH, 16'd7);
    waitMatch(100, k);
    check("R8", "deferred keeps old compare", k, 2);
    waitMatch(100, k);
    check("R8", "deferred new compare next period", k, 13);
    check("R8", "count at new match", count, 7);
    writeReg(A_CTRL, 16'h0);
    writeReg(A_CTRL, EN | PER | MEN);
    writeReg(A_MATCH, 16'd5);
    waitMatch(100, k);
    check("R8", "immediate compare", k, 3);
    writeReg(A_CTRL, 16'h0);
    writeReg(A_CTRL, EN | PER);
    seen = 0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      if (matchPulse) seen++;
    end
    check("R9", "no match when disabled", seen, 0);
    writeReg(A_CTRL, 16'h0);

    // R3 carry into prescaler bits with extended compare (R9)
    writeReg(A_LOAD, 16'd0);
    writeReg(A_PSC, 16'd1);
    writeReg(A_MATCH, 16'd0);
    writeReg(A_PSM, 16'd1);
    writeReg(A_CTRL, EN | PER | MEN);
    repeat (65535) @(negedge clk);
    check("R3", "count before carry", count, 16'hFFFF);
    check("R3", "prescale before carry", prescaleSnap, 0);
    @(negedge clk);
    check("R3", "count after carry", count, 0);
    check("R3", "prescale after carry", prescaleSnap, 1);
    check("R4", "no timeout at carry", timeoutPulse, 0);
    check("R9", "extended match", matchPulse, 1);
    @(negedge clk);
    check("R4", "up timeout at 24-bit limit", timeoutPulse, 1);
    check("R4", "wrap prescale", prescaleSnap, 0);
    writeReg(A_CTRL, 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule